// File: doc/BRIEF.md
# Streaming Video Luma Histogram

This block watches a valid/ready video stream and builds a histogram of luma values for one field or frame. It sits beside the link as a passive monitor: it holds its ready output high at all times, so it never stalls the source, and it counts only the luma samples that belong to the payload of video data packets. Every packet opens with a header word that carries the packet type. Header words and every word of other packet types, such as the control packet sent before each field, are never counted.

Two bus layouts are supported and picked by a mode input. In parallel layout each 16-bit word carries luma and chroma side by side. In sequential layout the colour planes alternate on the low byte, luma first. All signals share the system clock. Pixels arrive slower than that clock, so the valid line drops between words, and no counting happens on those cycles.

When the last word of a video packet is accepted, a one-cycle done pulse marks the histogram as complete. The 256 bins can then be read through an address/data port with one cycle of read latency. The next video packet header clears the bins.

Top module: `luma_hist`

## Requirements
- R1: `st_ready` is high on every cycle after reset.
- R2: A word is taken only on a cycle with `st_valid` high. Cycles with `st_valid` low change no bin, even if `st_sop`, `st_eop` or `st_data` toggle.
- R3: A word accepted with `st_sop` high is a header. Its bits 3:0 give the packet type, where 0 means video data. A header word is never counted.
- R4: For a packet whose header type is not 0, no word of the packet changes any bin and no done pulse is produced.
- R5: With `par_mode` = 1, each payload word of a video packet adds one to the bin indexed by `st_data[15:8]`. Bits 7:0 are ignored.
- R6: With `par_mode` = 0, the payload words of a video packet alternate luma and chroma in `st_data[7:0]`. Only the 1st, 3rd, 5th and later odd-numbered words are counted, and `st_data[15:8]` is ignored.
- R7: All 256 bins read zero after reset. Accepting the header of a video packet sets every bin back to zero before its payload is counted.
- R8: `done` is high for exactly one cycle: the cycle after the end-of-packet word of a video packet is accepted.
- R9: `rd_data` shows the count of bin `rd_addr` on the cycle after the address is applied, and includes every word accepted before the address was applied.
- R10: Each bin is 18 bits wide and counts past 255 without wrapping, up to 262143, which covers a 720 by 240 field of one luma value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| par_mode | input | 1 | 1: luma and chroma side by side on 16 bits; 0: alternating on the low byte |
| st_valid | input | 1 | Source has a word on the bus |
| st_ready | output | 1 | Always high; the monitor never back-pressures |
| st_sop | input | 1 | First word of a packet (header) |
| st_eop | input | 1 | Last word of a packet |
| st_data | input | 16 | Stream word |
| rd_addr | input | 8 | Bin index to read |
| rd_data | output | 18 | Count of the addressed bin, one cycle after the address |
| done | output | 1 | One-cycle pulse after a video packet ends |

## Verification
A parser stuck in the wrong packet state shows up in the first readout after the packet: bins that should be empty hold counts from control packets or header bytes, or a done pulse appears for a control packet or goes missing for a video one. A sequential-mode phase error shifts the whole histogram onto the chroma values, so every touched bin is wrong in the next readout. A stale clear flag makes one bin read a count left from the earlier field. That shows up as soon as that bin is addressed, one cycle later.

// File: rtl/luma_hist_pkg.sv
package luma_hist_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_VIDEO = 2'd1,
    PS_SKIP  = 2'd2
  } pkt_state_t;

  localparam int unsigned TYPE_VIDEO = 0;

endpackage

// File: rtl/lh_parser.sv
module lh_parser
  import luma_hist_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int LUMA_W = 8,
  parameter int TYPE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              par_mode,
  input  logic              valid,
  input  logic              sop,
  input  logic              eop,
  input  logic [DATA_W-1:0] data,
  output logic              inc_en,
  output logic [LUMA_W-1:0] inc_bin,
  output logic              clr,
  output logic              done
);

  pkt_state_t state;
  logic       phase;     // 0: next sequential word is luma
  logic       hdr;
  logic       payload;

  always_comb begin
    hdr     = valid && sop;
    clr     = hdr && (data[TYPE_W-1:0] == TYPE_W'(TYPE_VIDEO));
    payload = valid && !sop && (state == PS_VIDEO);
    inc_en  = payload && (par_mode || !phase);
    inc_bin = par_mode ? data[DATA_W-1 -: LUMA_W] : data[LUMA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= PS_IDLE;
      phase <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= payload && eop;
      if (hdr) begin
        phase <= 1'b0;
        if (eop)      state <= PS_IDLE;
        else if (clr) state <= PS_VIDEO;
        else          state <= PS_SKIP;
      end else if (valid && state != PS_IDLE) begin
        if (payload) phase <= ~phase;
        if (eop)     state <= PS_IDLE;
      end
    end
  end

  // R8: done never lasts beyond one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: nothing is counted while a non-video packet is being skipped
  assert_skip_silent_R4: assert property (@(posedge clk) disable iff (rst)
    (state == PS_SKIP) |-> !inc_en);

  // R6: two sequential-mode payload words in a row are never both counted
  assert_seq_alternate_R6: assert property (@(posedge clk) disable iff (rst)
    (payload && !par_mode && $past(inc_en) && $past(!par_mode) && !$past(clr))
      |-> !inc_en);

endmodule

// File: rtl/lh_bins.sv
module lh_bins #(
  parameter int LUMA_W  = 8,
  parameter int COUNT_W = 18
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               inc_en,
  input  logic [LUMA_W-1:0]  inc_bin,
  input  logic [LUMA_W-1:0]  rd_addr,
  output logic [COUNT_W-1:0] rd_data
);

  localparam int NBINS = 1 << LUMA_W;

  logic [COUNT_W-1:0] mem [NBINS];
  logic [NBINS-1:0]   live;      // bin written since last clear
  logic [COUNT_W-1:0] cur;

  always_comb cur = live[inc_bin] ? mem[inc_bin] : '0;

  always_ff @(posedge clk) begin
    if (inc_en) mem[inc_bin] <= cur + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  live <= '0;
    else if (inc_en) live[inc_bin] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= live[rd_addr] ? mem[rd_addr] : '0;
  end

  // R7: a clear empties every bin on the next cycle
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (rst)
    clr |=> (live == '0));

  // R10: a bin is never incremented from its full-scale value
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    inc_en |-> (cur != {COUNT_W{1'b1}}));

endmodule

// File: rtl/luma_hist.sv
module luma_hist #(
  parameter int LUMA_W  = 8,
  parameter int DATA_W  = 2 * LUMA_W,
  parameter int COUNT_W = 18,
  parameter int TYPE_W  = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               par_mode,
  input  logic               st_valid,
  output logic               st_ready,
  input  logic               st_sop,
  input  logic               st_eop,
  input  logic [DATA_W-1:0]  st_data,
  input  logic [LUMA_W-1:0]  rd_addr,
  output logic [COUNT_W-1:0] rd_data,
  output logic               done
);

  logic              inc_en;
  logic [LUMA_W-1:0] inc_bin;
  logic              clr;

  assign st_ready = 1'b1;

  lh_parser #(
    .DATA_W (DATA_W),
    .LUMA_W (LUMA_W),
    .TYPE_W (TYPE_W)
  ) parser_i (
    .clk      (clk),
    .rst      (rst),
    .par_mode (par_mode),
    .valid    (st_valid),
    .sop      (st_sop),
    .eop      (st_eop),
    .data     (st_data),
    .inc_en   (inc_en),
    .inc_bin  (inc_bin),
    .clr      (clr),
    .done     (done)
  );

  lh_bins #(
    .LUMA_W  (LUMA_W),
    .COUNT_W (COUNT_W)
  ) bins_i (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .inc_en  (inc_en),
    .inc_bin (inc_bin),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  // R2/R3: counting only happens on a valid, non-header beat
  assert_count_on_payload_R3: assert property (@(posedge clk) disable iff (rst)
    inc_en |-> (st_valid && !st_sop));

endmodule

// File: tb/luma_hist_tb_top.sv
module luma_hist_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  typedef struct packed {
    logic        par;
    logic [3:0]  ptype;
    logic [15:0] nwords;
    logic [7:0]  base;
    logic [7:0]  step;
    logic        gaps;
  } vec_t;

  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0,  16'd40,  8'd3,   8'd7, 1'b1},
    '{1'b0, 4'd0,  16'd50,  8'd200, 8'd5, 1'b0},
    '{1'b1, 4'd15, 16'd20,  8'd9,   8'd1, 1'b0},
    '{1'b0, 4'd0,  16'd31,  8'd0,   8'd1, 1'b1},
    '{1'b1, 4'd6,  16'd10,  8'd77,  8'd3, 1'b1},
    '{1'b1, 4'd0,  16'd600, 8'h5A,  8'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        par_mode;
  logic        st_valid;
  logic        st_ready;
  logic        st_sop;
  logic        st_eop;
  logic [15:0] st_data;
  logic [7:0]  rd_addr;
  logic [17:0] rd_data;
  logic        done;

  int checks = 0;
  int errors = 0;
  int ready_bad = 0;
  int exp_cnt [256];

  always #(CLK_PERIOD / 2) clk = ~clk;

  luma_hist dut_i (
    .clk      (clk),
    .rst      (rst),
    .par_mode (par_mode),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .st_sop   (st_sop),
    .st_eop   (st_eop),
    .st_data  (st_data),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .done     (done)
  );

  always @(negedge clk) if (!rst && st_ready !== 1'b1) ready_bad++;

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic send_word(input logic [15:0] d, input logic s, input logic e,
                           input logic g);
    if (g) begin
      st_valid = 1'b0; st_sop = 1'b1; st_eop = 1'b1; st_data = 16'($urandom);
      @(negedge clk);
    end
    st_valid = 1'b1; st_sop = s; st_eop = e; st_data = d;
    @(negedge clk);
  endtask

  task automatic send_packet(input vec_t v);
    logic [7:0] luma, chroma;
    logic [15:0] d;
    string tag;
    tag = (v.ptype != 0) ? "R4 control" : (v.par ? "R8 par" : "R8 seq");
    par_mode = v.par;
    send_word({12'hABC, v.ptype}, 1'b1, 1'b0, v.gaps);
    if (v.ptype == 0) for (int b = 0; b < 256; b++) exp_cnt[b] = 0;
    for (int i = 0; i < int'(v.nwords); i++) begin
      luma   = v.base + 8'((v.par ? i : i / 2) * int'(v.step));
      chroma = luma ^ 8'hA5;
      if (v.par)        d = {luma, chroma};
      else if (i % 2 == 0) d = {chroma, luma};
      else              d = {luma, chroma};
      send_word(d, 1'b0, i == int'(v.nwords) - 1, v.gaps);
      if (v.ptype == 0 && (v.par || i % 2 == 0)) exp_cnt[luma]++;
    end
    st_valid = 1'b0; st_sop = 1'b0; st_eop = 1'b0;
    chk({tag, " done after eop"}, int'(done), (v.ptype == 0) ? 1 : 0);
    @(negedge clk);
    chk({tag, " done width"}, int'(done), 0);
  endtask

  task automatic read_bin(input int b, output int val);
    rd_addr = 8'(b);
    @(negedge clk);
    val = int'(rd_data);
  endtask

  task automatic dump(input string req);
    int val;
    for (int b = 0; b < 256; b++) begin
      read_bin(b, val);
      chk(req, val, exp_cnt[b]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 150000 cycles expected fewer");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int val;
    rst = 1'b1; par_mode = 1'b1; st_valid = 1'b0; st_sop = 1'b0;
    st_eop = 1'b0; st_data = '0; rd_addr = '0;
    for (int b = 0; b < 256; b++) exp_cnt[b] = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R8 reset done", int'(done), 0);
    chk("R1 reset ready", int'(st_ready), 1);
    read_bin(5, val);
    chk("R7/R9 reset bin 5", val, 0);
    read_bin(255, val);
    chk("R7/R9 reset bin 255", val, 0);

    // table-driven packets: gaps exercise R2, headers R3, clears R7
    for (int k = 0; k < NV; k++) begin
      send_packet(VEC[k]);
      if (VEC[k].ptype != 0)   dump("R4 bins unchanged after control packet");
      else if (VEC[k].par)     dump("R2/R3/R5/R7/R9 parallel bins");
      else                     dump("R2/R3/R6/R7/R9 sequential bins");
    end

    // R10: one bin past 8 bits
    read_bin(8'h5A, val);
    chk("R10 wide bin count", val, 600);
    read_bin(8'h5A ^ 8'hA5, val);
    chk("R5 chroma byte not counted", val, 0);

    // R2: idle toggling with valid low leaves bins alone
    for (int i = 0; i < 8; i++) begin
      st_valid = 1'b0; st_sop = 1'(i); st_eop = 1'(i >> 1); st_data = 16'h5A5A;
      @(negedge clk);
    end
    st_sop = 1'b0; st_eop = 1'b0;
    read_bin(8'h5A, val);
    chk("R2 valid low ignored", val, 600);
    chk("R8 no done while idle", int'(done), 0);

    chk("R1 ready always high", ready_bad, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule